// File: doc/BRIEF.md
# Polled SPI Master with Register Interface

This block is a single-chip-select SPI master that a processor drives through five 32-bit registers on a simple synchronous bus. Software first sets the word size and the serial clock divisor in a configuration register. It then asserts the chip select through a control bit and writes a word to the transmit register. That write starts one full-duplex exchange in clock-idle-low, sample-on-rising-edge mode. Bits travel most significant first.

The serial clock is derived from the system clock by an even divide ratio between 4 and 30. Each half period lasts the same number of system clocks. When the last bit has been clocked, the received word is stored in the receive register and a completion flag is raised. Software polls that flag and clears it by writing zero before the next word.

Top module: `spim_ctrl`

## Requirements
- R1: Control register (offset 0x00) bit 0 drives the chip select. Writing 1 drives `spi_cs_n` low from the next cycle, and writing 0 drives it high. The bit reads back at bit 0.
- R2: Configuration register (offset 0x04) holds 6 writable bits [5:0] that read back unchanged. Bit 5 = 1 selects 16-bit words and bit 5 = 0 selects 8-bit words.
- R3: Configuration bits [4:0] are a divisor code. The half period H equals code − 16, so `spi_sck` stays high for H system clocks and low for H system clocks. An N-bit word keeps the busy bit set for exactly 2·H·N cycles, counted from the clock edge that accepts the transmit write.
- R4: Divisor codes below 0x12 behave as 0x12 (H = 2).
- R5: `spi_sck` is low whenever no exchange is running. `spi_mosi` changes only while `spi_sck` is low. `spi_miso` is captured as the clock rises.
- R6: Writing the transmit register (offset 0x08) while idle starts one exchange, most significant bit first. In 8-bit mode only write data [7:0] is sent. The transmit register reads as zero.
- R7: Completion sets cause register (offset 0x10) bit 0 to 1. A write whose bit 0 is 0 clears it. A write whose bit 0 is 1 leaves it unchanged.
- R8: The receive register (offset 0x0C) holds the last received word in bits [15:0]. In 8-bit mode bits [15:8] read zero.
- R9: Control bit 1 reads 1 while an exchange is running. A transmit write while busy is ignored: the running word's length and content are unchanged.
- R10: Unused register bits read zero. Reads and writes at any other offset, including unaligned ones, have no effect and read zero.
- R11: After reset `spi_cs_n` is high, `spi_sck` is low, and the control, configuration, receive and cause registers read zero.
- R12: Word size and divisor are captured when an exchange starts. A configuration write during an exchange does not change that exchange's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational, zero unless reading |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
Exchanges are run against a modelled slave over a table that mixes both word sizes with the fastest, slowest, a middle and several clamped divisor codes. The table also includes transmit words whose upper byte must be dropped in 8-bit mode and an all-zero receive-only word. Each run measures busy length and total clock-high time, which separates a wrong divisor or clamp from a wrong bit count. The run also compares the bits the slave captured with the bits it returned, which exposes ordering and sampling-edge faults. Directed cases then inject a transmit write and a configuration write mid-word, probe out-of-range and unaligned offsets, and check the set/clear rules of the completion flag.

// File: rtl/spim_ctrl.sv
module spim_ctrl #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          spi_sck,
  output logic          spi_mosi,
  input  logic          spi_miso,
  output logic          spi_cs_n
);
  localparam logic [AW-1:0] A_CTRL  = AW'('h00);
  localparam logic [AW-1:0] A_CFG   = AW'('h04);
  localparam logic [AW-1:0] A_TX    = AW'('h08);
  localparam logic [AW-1:0] A_RX    = AW'('h0C);
  localparam logic [AW-1:0] A_CAUSE = AW'('h10);

  logic        cs_q, busy_q, sck_q, w16_q, done_q;
  logic [5:0]  cfg_q;
  logic [3:0]  half_q, div_q, bit_q;
  logic [15:0] txs_q, rxs_q, rx_q;

  logic wr_ctrl, wr_cfg, wr_tx, wr_cause, rd;
  assign wr_ctrl  = bus_sel && bus_wr && bus_addr == A_CTRL;
  assign wr_cfg   = bus_sel && bus_wr && bus_addr == A_CFG;
  assign wr_tx    = bus_sel && bus_wr && bus_addr == A_TX;
  assign wr_cause = bus_sel && bus_wr && bus_addr == A_CAUSE;
  assign rd       = bus_sel && !bus_wr;

  logic [3:0] half_now, last_bit;
  logic       start, tick, rise, fall, fin;
  assign half_now = (cfg_q[4:0] < 5'h12) ? 4'd2 : cfg_q[3:0];
  assign last_bit = w16_q ? 4'd15 : 4'd7;
  assign start    = wr_tx && !busy_q;
  assign tick     = busy_q && (div_q == half_q - 4'd1);
  assign rise     = tick && !sck_q;
  assign fall     = tick && sck_q;
  assign fin      = fall && (bit_q == last_bit);

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata[DW-1:16];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 1'b0;
      cfg_q <= '0;
    end else begin
      if (wr_ctrl) cs_q  <= bus_wdata[0];
      if (wr_cfg)  cfg_q <= bus_wdata[5:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      w16_q  <= 1'b0;
      half_q <= 4'd2;
      div_q  <= '0;
      bit_q  <= '0;
      txs_q  <= '0;
      rxs_q  <= '0;
      rx_q   <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      sck_q  <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      half_q <= half_now;
      w16_q  <= cfg_q[5];
      txs_q  <= cfg_q[5] ? bus_wdata[15:0] : {bus_wdata[7:0], 8'h00};
    end else if (busy_q) begin
      div_q <= tick ? 4'd0 : div_q + 4'd1;
      if (rise) begin
        sck_q <= 1'b1;
        rxs_q <= {rxs_q[14:0], spi_miso};
      end
      if (fall) begin
        sck_q <= 1'b0;
        if (fin) begin
          busy_q <= 1'b0;
          rx_q   <= w16_q ? rxs_q : {8'h00, rxs_q[7:0]};
        end else begin
          bit_q <= bit_q + 4'd1;
          txs_q <= txs_q << 1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        done_q <= 1'b0;
    else if (fin)                      done_q <= 1'b1;
    else if (wr_cause && !bus_wdata[0]) done_q <= 1'b0;
  end

  assign spi_sck  = sck_q;
  assign spi_mosi = txs_q[15];
  assign spi_cs_n = !cs_q;

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (bus_addr)
        A_CTRL:  bus_rdata[1:0]  = {busy_q, cs_q};
        A_CFG:   bus_rdata[5:0]  = cfg_q;
        A_RX:    bus_rdata[15:0] = rx_q;
        A_CAUSE: bus_rdata[0]    = done_q;
        default: bus_rdata       = '0;
      endcase
    end
  end

  // R1
  cs_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> spi_cs_n == !$past(bus_wdata[0]));

  // R5
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !spi_sck);

  // R7
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $fell(busy_q));

  // R12
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(half_q) && $stable(w16_q));

  // R3
  div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (div_q < half_q) && (half_q >= 4'd2));

  // R6
  bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> bit_q <= last_bit);
endmodule

// File: tb/spim_ctrl_tb_top.sv
module spim_ctrl_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        spi_sck, spi_mosi, spi_miso, spi_cs_n;

  always #10 clk = ~clk;

  spim_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  int n_chk = 0, n_bad = 0;
  logic [15:0] slv = '0, cap = '0;
  logic        mode16 = 1'b0;
  assign spi_miso = mode16 ? slv[15] : slv[7];
  always @(posedge spi_sck) cap <= {cap[14:0], spi_mosi};
  always @(negedge spi_sck) slv <= slv << 1;

  int hi_cnt = 0, mosi_bad = 0;
  logic sck_prev = 1'b0, mosi_prev = 1'b0;
  always @(negedge clk) begin
    if (sck_prev && spi_sck && spi_mosi != mosi_prev) mosi_bad = mosi_bad + 1;
    if (spi_sck) hi_cnt = hi_cnt + 1;
    sck_prev  = spi_sck;
    mosi_prev = spi_mosi;
  end

  localparam logic [37:0] VEC [7] = '{
    {6'h12, 16'h00A5, 16'h003C},
    {6'h32, 16'hBEEF, 16'h1234},
    {6'h1F, 16'hFF81, 16'h00C3},
    {6'h35, 16'h8001, 16'hFFFF},
    {6'h05, 16'h0000, 16'h005A},
    {6'h30, 16'h7FFE, 16'h0001},
    {6'h11, 16'h0001, 16'h0080}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  function automatic int exp_half(input logic [5:0] c);
    return (c[4:0] < 5'h12) ? 2 : int'(c[4:0]) - 16;
  endfunction

  // mode: 0 plain, 1 extra transmit write mid-word, 2 configuration write mid-word
  task automatic run(input logic [5:0] cfg, input logic [15:0] tx, input logic [15:0] sw, input int mode);
    logic [31:0] d;
    int cnt, h, nb, t_exp;
    logic mid_busy;
    logic [15:0] cap_exp, rx_exp;
    h = exp_half(cfg);
    nb = cfg[5] ? 16 : 8;
    t_exp = 2 * h * nb;
    cap_exp = cfg[5] ? tx : {8'h00, tx[7:0]};
    rx_exp  = cfg[5] ? sw : {8'h00, sw[7:0]};
    wr(8'h04, {26'h0, cfg});
    wr(8'h10, 32'h0);
    wr(8'h00, 32'h1);
    mode16 = cfg[5]; slv = sw; cap = '0; hi_cnt = 0;
    wr(8'h08, {16'hC0DE, tx});
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h00;
    cnt = 0; mid_busy = 1'b0;
    forever begin
      #1;
      if (!bus_wr && !bus_rdata[1]) break;
      if (cnt == 1) mid_busy = bus_rdata[1];
      cnt++;
      if (cnt > 2000) break;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = 8'h00;
      if (cnt == 3 && mode == 1) begin bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = 32'h33; end
      if (cnt == 3 && mode == 2) begin bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h3F; end
    end
    bus_sel = 1'b0; bus_wr = 1'b0;
    chk(mid_busy == 1'b1, "R9 busy bit during word", 32'(mid_busy), 32'h1);
    chk(cnt == t_exp, mode == 2 ? "R12 length after mid-word cfg write" :
                      mode == 1 ? "R9 length after ignored tx write" : "R3/R4 word length", cnt, t_exp);
    chk(hi_cnt == h * nb, "R3 sck high time", hi_cnt, h * nb);
    chk((cfg[5] ? cap : {8'h00, cap[7:0]}) == cap_exp, "R6 bits sent msb first", cap, cap_exp);
    chk(spi_cs_n == 1'b0, "R1 cs held during word", 32'(spi_cs_n), 32'h0);
    rd(8'h0C, d);
    chk(d == {16'h0, rx_exp}, "R8 received word", d, {16'h0, rx_exp});
    rd(8'h10, d);
    chk(d == 32'h1, "R7 cause set", d, 32'h1);
    wr(8'h10, 32'h1);
    rd(8'h10, d);
    chk(d == 32'h1, "R7 write of 1 keeps cause", d, 32'h1);
    wr(8'h10, 32'h0);
    rd(8'h10, d);
    chk(d == 32'h0, "R7 write of 0 clears cause", d, 32'h0);
    wr(8'h00, 32'h0);
    chk(spi_cs_n == 1'b1, "R1 cs released", 32'(spi_cs_n), 32'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R11 pins in reset", {spi_cs_n, spi_sck}, 32'h2);
    rst_n = 1'b1;
    rd(8'h00, d); chk(d == 0, "R11 control after reset", d, 0);
    rd(8'h04, d); chk(d == 0, "R11 config after reset", d, 0);
    rd(8'h0C, d); chk(d == 0, "R11 receive after reset", d, 0);
    rd(8'h10, d); chk(d == 0, "R11 cause after reset", d, 0);
    chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R11 pins after reset", {spi_cs_n, spi_sck}, 32'h2);

    wr(8'h00, 32'hFFFF_FFFD);
    chk(spi_cs_n == 1'b0, "R1 cs asserted", 32'(spi_cs_n), 32'h0);
    rd(8'h00, d); chk(d == 32'h1, "R1/R10 control readback", d, 32'h1);
    wr(8'h00, 32'h0);
    chk(spi_cs_n == 1'b1, "R1 cs released", 32'(spi_cs_n), 32'h1);

    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, d); chk(d == 32'h3F, "R2 config readback", d, 32'h3F);
    wr(8'h04, 32'h0000_0015);
    rd(8'h04, d); chk(d == 32'h15, "R2 config readback", d, 32'h15);

    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h01, 32'hFFFF_FFFF);
    wr(8'h05, 32'hFFFF_FFFF);
    chk(spi_cs_n == 1'b1, "R10 stray write leaves cs", 32'(spi_cs_n), 32'h1);
    rd(8'h04, d); chk(d == 32'h15, "R10 stray write leaves config", d, 32'h15);
    rd(8'h14, d); chk(d == 0, "R10 out-of-range read", d, 0);
    rd(8'h02, d); chk(d == 0, "R10 unaligned read", d, 0);
    rd(8'h08, d); chk(d == 0, "R6 transmit reads zero", d, 0);
    rd(8'h10, d); chk(d == 0, "R10 no exchange started", d, 0);

    for (int i = 0; i < 7; i++)
      run(VEC[i][37:32], VEC[i][31:16], VEC[i][15:0], 0);

    run(6'h12, 16'h005A, 16'h00A5, 1);
    run(6'h12, 16'h00C3, 16'h003C, 2);
    chk(mosi_bad == 0, "R5 mosi stable while sck high", mosi_bad, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule